// File: doc/BRIEF.md
# Subcode Q Capture and Serial Readout

This block assembles the Q channel of the disc subcode into an 80-bit holding register and hands it to a host controller over a clocked serial link. The decoder upstream supplies one Q bit per frame with a bit strobe. At the end of each subcode block it supplies an end-of-block strobe, together with a CRC verdict and flags for the two subcode sync patterns. A block is taken into the holding register only when all three flags are good and the host is not in a read session. The block then raises an active-low ready level and an active-low strobe pulse of fixed length.

The host reads by pulling its latch line low and applying rising edges on its serial clock. When the latch falls while data is ready and the strobe has ended, the first data bit appears on the serial output at once. Each host rising edge advances the output by one bit. Bytes leave in arrival order, but the bits inside each byte leave in reverse order. The 81st rising edge of a session ends readiness. A session that starts while the strobe is still low gets a constant not-ready level. Any session that runs to 81 edges clears readiness, which is also how a host recovers from an aborted read. All inputs are sampled on the block's own clock.

Top module: `sq_capture_top`

## Requirements
- R1: After reset, rdy_n and stb_n are 1, and host_sdo is 1.
- R2: A block is captured at an end-of-block strobe only if crc_ok, sync0_ok and sync1_ok are all 1 and host_latch_n is 1. A capture drives rdy_n to 0 in the next cycle. If any of the three flags is 0, rdy_n stays 1.
- R3: After a capture, stb_n is 0 for exactly STB_LEN (default 16) cycles, starting the cycle after the capture.
- R4: While host_latch_n is 0, the holding register is not renewed. A session then reads the older block, and a block that ends during the session is never captured.
- R5: When host_latch_n falls while rdy_n is 0 and stb_n is 1, the first bit appears on host_sdo in the next cycle. Each host_sck rising edge advances host_sdo by one bit, for 80 bits.
- R6: Bytes are output in arrival order (first-received byte first). Within each byte, the last-received bit is output first.
- R7: The 81st host_sck rising edge of a session sets rdy_n to 1.
- R8: If host_latch_n falls while stb_n is 0, host_sdo stays 1 (not ready) for the whole session.
- R9: If a session ends before 81 edges, rdy_n stays 0. A later session restarts from the first bit. Any session of 81 edges, good or not, leaves rdy_n at 1.
- R10: With host_latch_n high, host_sdo mirrors rdy_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_bit | input | 1 | Subcode Q bit of the current frame |
| q_stb | input | 1 | Strobe that shifts q_bit into the assembly register |
| blk_stb | input | 1 | End of subcode block |
| crc_ok | input | 1 | CRC verdict for the block, 1 = good |
| sync0_ok | input | 1 | First sync pattern seen in place |
| sync1_ok | input | 1 | Second sync pattern seen in place |
| host_sck | input | 1 | Host serial clock, data advances on the rising edge |
| host_latch_n | input | 1 | Host latch; low opens a read session |
| host_sdo | output | 1 | Serial data or status to the host |
| rdy_n | output | 1 | Ready level, 0 = data ready |
| stb_n | output | 1 | Ready strobe, low for STB_LEN cycles after a capture |

## Verification
An end-of-block strobe sampled at one edge shows on rdy_n and stb_n one cycle later. A latch fall or a host clock rise sampled at one edge changes host_sdo one cycle later. The bench drives every input on the falling clock edge and samples the outputs on the next falling edge, which leaves exactly one register stage between them. The strobe length is measured by counting falling edges with stb_n low. Serial bits are compared in order through a queue of expected bits, so a shift that is early or late by one bit shows up as a mismatch.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_GOOD = 2'd1,
        SQ_BAD  = 2'd2
    } sq_sess_e;
endpackage

// File: rtl/sq_collect.sv
module sq_collect #(
    parameter int unsigned W = 80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_stb,
    output logic [W-1:0] word
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (bit_stb) acc_d = {acc_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word = acc_q;
endmodule

// File: rtl/sq_reorder.sv
module sq_reorder #(
    parameter int unsigned W = 80,
    parameter int unsigned G = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned NB = W / G;

    // dout is sent MSB first; position k = j*G+i takes bit i of byte j
    // counted from the byte's last-received bit.
    for (genvar j = 0; j < NB; j++) begin : g_byte
        for (genvar i = 0; i < G; i++) begin : g_bit
            assign dout[W-1-(j*G+i)] = din[W-G-j*G+i];
        end
    end
endmodule

// File: rtl/sq_capture_top.sv
module sq_capture_top
    import sq_pkg::*;
#(
    parameter int unsigned QW      = 80,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned STB_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q_bit,
    input  logic q_stb,
    input  logic blk_stb,
    input  logic crc_ok,
    input  logic sync0_ok,
    input  logic sync1_ok,
    input  logic host_sck,
    input  logic host_latch_n,
    output logic host_sdo,
    output logic rdy_n,
    output logic stb_n
);
    localparam int unsigned CW = $clog2(QW + 2);
    localparam int unsigned SW = $clog2(STB_LEN + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(QW + 1);
    localparam logic [CW-1:0] CLR_CNT  = CW'(QW);
    localparam logic [SW-1:0] STB_INIT = SW'(STB_LEN);

    typedef struct packed {
        logic [QW-1:0] hold;
        logic [QW-1:0] sr;
        logic [CW-1:0] cnt;
        logic [SW-1:0] stb;
        logic          ready;
        sq_sess_e      sess;
        logic          sck_prv;
        logic          lat_prv;
    } sq_state_t;

    sq_state_t s_d, s_q;

    logic [QW-1:0] asm_word;
    logic [QW-1:0] out_word;
    logic          sck_rise, lat_fall, lat_rise, take;

    sq_collect #(.W(QW)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (q_bit),
        .bit_stb (q_stb),
        .word    (asm_word)
    );

    sq_reorder #(.W(QW), .G(BYTE_W)) u_reorder (
        .din  (s_q.hold),
        .dout (out_word)
    );

    assign sck_rise = host_sck & ~s_q.sck_prv;
    assign lat_fall = ~host_latch_n & s_q.lat_prv;
    assign lat_rise = host_latch_n & ~s_q.lat_prv;
    assign take     = blk_stb & crc_ok & sync0_ok & sync1_ok & host_latch_n;

    always_comb begin
        s_d         = s_q;
        s_d.sck_prv = host_sck;
        s_d.lat_prv = host_latch_n;

        if (s_q.stb != '0) s_d.stb = s_q.stb - 1'b1;

        if (take) begin
            s_d.hold  = asm_word;
            s_d.ready = 1'b1;
            s_d.stb   = STB_INIT;
        end

        if (lat_fall) begin
            s_d.cnt = '0;
            if (s_q.ready && s_q.stb == '0) begin
                s_d.sess = SQ_GOOD;
                s_d.sr   = out_word;
            end else begin
                s_d.sess = SQ_BAD;
            end
        end else if (lat_rise) begin
            s_d.sess = SQ_IDLE;
        end else if (s_q.sess != SQ_IDLE && sck_rise && s_q.cnt != LAST_CNT) begin
            s_d.cnt = s_q.cnt + 1'b1;
            s_d.sr  = {s_q.sr[QW-2:0], 1'b0};
            if (s_q.cnt == CLR_CNT) begin
                s_d.hold  = '0;
                s_d.ready = 1'b0;
                s_d.stb   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hold    <= '0;
            s_q.sr      <= '0;
            s_q.cnt     <= '0;
            s_q.stb     <= '0;
            s_q.ready   <= 1'b0;
            s_q.sess    <= SQ_IDLE;
            s_q.sck_prv <= 1'b0;
            s_q.lat_prv <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy_n = ~s_q.ready;
    assign stb_n = (s_q.stb == '0);

    always_comb begin
        case (s_q.sess)
            SQ_GOOD: host_sdo = s_q.sr[QW-1];
            SQ_BAD:  host_sdo = 1'b1;
            default: host_sdo = ~s_q.ready;
        endcase
    end
endmodule

// File: rtl/sq_capture_chk.sv
module sq_capture_chk (
    input logic clk,
    input logic rst_n,
    input logic blk_stb,
    input logic crc_ok,
    input logic sync0_ok,
    input logic sync1_ok,
    input logic host_sck,
    input logic host_latch_n,
    input logic rdy_n,
    input logic stb_n
);
    // R2
    cap_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n) |-> $past(blk_stb && crc_ok && sync0_ok && sync1_ok));

    // R4
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(host_latch_n));

    // R3
    stb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |-> !rdy_n);

    // R7
    clr_sess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(!host_latch_n && host_sck));
endmodule

bind sq_capture_top sq_capture_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .blk_stb      (blk_stb),
    .crc_ok       (crc_ok),
    .sync0_ok     (sync0_ok),
    .sync1_ok     (sync1_ok),
    .host_sck     (host_sck),
    .host_latch_n (host_latch_n),
    .rdy_n        (rdy_n),
    .stb_n        (stb_n)
);

// File: tb/sq_capture_top_tb.sv
module sq_capture_top_tb;
    localparam int QW = 80;
    localparam int STB_LEN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic q_bit = 1'b0, q_stb = 1'b0, blk_stb = 1'b0;
    logic crc_ok = 1'b0, sync0_ok = 1'b0, sync1_ok = 1'b0;
    logic host_sck = 1'b0, host_latch_n = 1'b1;
    logic host_sdo, rdy_n, stb_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];
    logic  act_q[$];

    always #4 clk = ~clk;

    sq_capture_top #(.QW(QW), .BYTE_W(8), .STB_LEN(STB_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .q_bit(q_bit), .q_stb(q_stb),
        .blk_stb(blk_stb), .crc_ok(crc_ok), .sync0_ok(sync0_ok),
        .sync1_ok(sync1_ok), .host_sck(host_sck), .host_latch_n(host_latch_n),
        .host_sdo(host_sdo), .rdy_n(rdy_n), .stb_n(stb_n)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares serial bits in order
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            logic a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s serial actual=%0b expected=%0b", t, a, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_block(input logic [QW-1:0] d, input logic c,
                              input logic s0, input logic s1);
        for (int i = QW - 1; i >= 0; i--) begin
            q_bit = d[i];
            q_stb = 1'b1;
            @(negedge clk);
        end
        q_stb = 1'b0;
        blk_stb = 1'b1; crc_ok = c; sync0_ok = s0; sync1_ok = s1;
        @(negedge clk);
        blk_stb = 1'b0; crc_ok = 1'b0; sync0_ok = 1'b0; sync1_ok = 1'b0;
    endtask

    // expected bit k: byte order kept, bits inside a byte reversed
    function automatic logic rev_bit(input logic [QW-1:0] d, input int k);
        int j, i;
        j = k / 8;
        i = k % 8;
        return d[72 - 8*j + i];
    endfunction

    task automatic sck_pulse();
        host_sck = 1'b1;
        @(negedge clk);
        host_sck = 1'b0;
        @(negedge clk);
    endtask

    task automatic latch_low();
        host_latch_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic latch_high();
        host_latch_n = 1'b1;
        @(negedge clk);
    endtask

    // driver: pushes expected data bits, samples, clocks n bits
    task automatic read_data(input logic [QW-1:0] d, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(rev_bit(d, k));
            tag_q.push_back(k == 0 ? {tag, "/R5"} : tag);
            act_q.push_back(host_sdo);
            sck_pulse();
        end
    endtask

    task automatic read_status(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(1'b1);
            tag_q.push_back(tag);
            act_q.push_back(host_sdo);
            sck_pulse();
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [QW-1:0] blk_a, blk_b, blk_c, blk_d;
        int low_cnt;
        blk_a = 80'hA1B2_C3D4_E5F6_0718_293A;
        blk_b = 80'h0F1E_2D3C_4B5A_6978_8796;
        blk_c = 80'h8001_4002_2004_1008_0810;
        blk_d = 80'h5555_AAAA_3333_CCCC_0F0F;

        wait_cyc(3);
        chk(rdy_n, 1, "R1 rdy_n");
        chk(stb_n, 1, "R1 stb_n");
        chk(host_sdo, 1, "R1 sdo");
        rst_n = 1'b1;
        wait_cyc(2);

        // good capture and strobe length
        send_block(blk_a, 1'b1, 1'b1, 1'b1);
        chk(rdy_n, 0, "R2 good block ready");
        chk(host_sdo, 0, "R10 sdo mirrors ready");
        low_cnt = 0;
        while (stb_n == 1'b0 && low_cnt < 100) begin
            low_cnt++;
            @(negedge clk);
        end
        chk(low_cnt, STB_LEN, "R3 strobe length");

        // full readout
        latch_low();
        read_data(blk_a, QW, "R6");
        chk(rdy_n, 0, "R7 ready before 81st");
        sck_pulse();
        chk(rdy_n, 1, "R7 ready cleared by 81st");
        latch_high();
        chk(host_sdo, 1, "R10 sdo mirrors not ready");

        // rejected blocks
        send_block(blk_b, 1'b0, 1'b1, 1'b1);
        chk(rdy_n, 1, "R2 crc fail");
        chk(stb_n, 1, "R2 crc fail strobe");
        send_block(blk_b, 1'b1, 1'b1, 1'b0);
        chk(rdy_n, 1, "R2 missing sync1");
        send_block(blk_b, 1'b1, 1'b0, 1'b1);
        chk(rdy_n, 1, "R2 missing sync0");

        // freeze while latch low
        send_block(blk_b, 1'b1, 1'b1, 1'b1);
        wait_cyc(STB_LEN + 4);
        latch_low();
        send_block(blk_c, 1'b1, 1'b1, 1'b1);
        chk(stb_n, 1, "R4 no strobe in session");
        read_data(blk_b, QW, "R4");
        sck_pulse();
        chk(rdy_n, 1, "R7 cleared after frozen read");
        latch_high();
        wait_cyc(2);
        chk(rdy_n, 1, "R4 block in session not captured");

        // aborted read and restart
        send_block(blk_c, 1'b1, 1'b1, 1'b1);
        wait_cyc(STB_LEN + 4);
        latch_low();
        read_data(blk_c, 20, "R9 partial");
        latch_high();
        chk(rdy_n, 0, "R9 ready kept after abort");
        latch_low();
        read_data(blk_c, QW, "R9 restart");
        sck_pulse();
        chk(rdy_n, 1, "R9 cleared after full restart");
        latch_high();

        // latch falls during strobe
        send_block(blk_d, 1'b1, 1'b1, 1'b1);
        wait_cyc(3);
        latch_low();
        read_status(QW + 1, "R8");
        chk(rdy_n, 1, "R9 recovery clears ready");
        chk(stb_n, 1, "R9 recovery strobe high");
        latch_high();
        chk(host_sdo, 1, "R10 sdo after recovery");

        wait_cyc(4);
        chk(exp_q.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule